// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the address stream for one two-dimensional DMA channel. Each block is a set of rows. The inner count gives the number of elements in a row, and the outer count gives the number of rows. Inside a row the address moves by a signed inner step after every element. After the last element of a row the address moves by a signed outer step instead. A single value therefore sets the jump to the next row. For example, to write a rectangle into a wider frame buffer, the outer step is (screen width − block width) × bytes per pixel + element size. A 480×272 frame at 24 bits per pixel over a 32-bit bus uses an inner count of 360 with both steps equal to 4.

The configuration is captured when the enable input rises. The captured values are the start address, the two counts, the two steps, the element width and the flow mode. Every accepted transfer (valid and ready both high) uses one address and advances the generator. In stop flow the generator halts after the last element and raises a sticky `done` flag. In repeat flow it returns to the start address and starts the block again without help. The data path, the bus protocol and arbitration are outside this block.

The controller is a four-state machine:
- **IDLE**: waiting for the enable input.
- **RUN**: offering addresses.
- **HALT**: the block is complete in stop flow.
- **FAULT**: a zero count was captured.

The transitions are:
- IDLE→RUN: enable with both counts nonzero.
- IDLE→FAULT: enable with a zero count.
- RUN→RUN: a transfer, including the wrap back to the start in repeat flow.
- RUN→HALT: the last transfer in stop flow.
- RUN→IDLE: disable, which aborts the block.
- HALT→IDLE and FAULT→IDLE: disable.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `addr_valid`, `run`, `done` and `err` are all 0.
- R2: One clock after `en` is sampled high in IDLE with both counts nonzero, `run` and `addr_valid` are 1 and `addr` equals the captured start address.
- R3: After an accepted transfer that is not the last of its row, `addr` advances by the sign-extended inner step, modulo 2^32.
- R4: After an accepted transfer that is the last of its row, but not of the block, `addr` advances by the sign-extended outer step, modulo 2^32.
- R5: In stop flow (`cfg_repeat`=0), exactly inner count × outer count addresses are offered. One clock after the last is accepted, `addr_valid` and `run` are 0 and `done` is 1.
- R6: `done` stays 1 until `done_clr` is sampled high, and is 0 one clock later. A completion in the same cycle as the clear wins.
- R7: In repeat flow (`cfg_repeat`=1), the address after the last element of the block is the start address again, the sequence repeats without limit, and `done` stays 0.
- R8: A captured inner or outer count of 0 sets `err` to 1 and offers no address. `err` returns to 0 one clock after `en` is sampled low.
- R9: Changes to the configuration inputs while `en` is high have no effect. They take effect at the next rising of `en`.
- R10: While `addr_valid` is 1 and `addr_ready` is 0, `addr` and `addr_valid` hold their values.
- R11: `en` sampled low during RUN drops `addr_valid` and `run` one clock later.
- R12: `xfer_wide` shows the captured element width (1 = 32-bit, 0 = 16-bit) while the channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Channel enable; rising captures configuration |
| cfg_start | input | 32 | Start address in bytes |
| cfg_xcnt | input | 16 | Elements per row |
| cfg_xstep | input | 16 | Signed byte step within a row |
| cfg_ycnt | input | 16 | Rows per block |
| cfg_ystep | input | 16 | Signed byte step after a row's last element |
| cfg_wide | input | 1 | Element width: 1 = 32-bit, 0 = 16-bit |
| cfg_repeat | input | 1 | Flow: 1 = repeat forever, 0 = stop at end |
| addr_ready | input | 1 | Consumer accepts the offered address |
| done_clr | input | 1 | Write-one-to-clear for `done` |
| addr_valid | output | 1 | An address is offered |
| addr | output | 32 | Offered byte address |
| xfer_wide | output | 1 | Captured element width |
| run | output | 1 | Transfers remain in the current block |
| done | output | 1 | Sticky completion flag (stop flow) |
| err | output | 1 | Zero count captured |

## Verification
The bench tests the row boundary: a design that applies the inner step on the last element of a row gives a wrong address at the start of every new row. Negative steps that cross address zero show whether sign extension and modulo wrap are right; a zero-extended step jumps near 2^16 instead. The bench holds `addr_ready` low to catch a generator that advances without a handshake. It changes the configuration in the middle of a block to catch a design that reads the live inputs. It also runs repeat flow past the block end to catch a missed reload or a false `done`, and gives zero counts to catch a design that offers addresses it should not.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
    parameter int ADDR_W = 32;
    parameter int CNT_W  = 16;
    parameter int STEP_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_HALT  = 2'd2,
        ST_FAULT = 2'd3
    } dma2d_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [CNT_W-1:0]  xcnt;
        logic [STEP_W-1:0] xstep;
        logic [CNT_W-1:0]  ycnt;
        logic [STEP_W-1:0] ystep;
        logic              wide;
        logic              repeat_en;
    } dma2d_cfg_t;
endpackage

// File: rtl/dma2d_cfg_reg.sv
module dma2d_cfg_reg
    import dma2d_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  dma2d_cfg_t cfg_d,
    output dma2d_cfg_t cfg_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (capture)
            cfg_q <= cfg_d;
    end
endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker
    import dma2d_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  dma2d_cfg_t        cfg_d,
    input  dma2d_cfg_t        cfg_q,
    output logic [ADDR_W-1:0] addr,
    output logic              row_end,
    output logic              blk_end
);
    localparam int EXT_W = ADDR_W - STEP_W;

    logic [CNT_W-1:0]  xrem, yrem;
    logic [ADDR_W-1:0] xinc, yinc;

    always_comb begin
        xinc    = {{EXT_W{cfg_q.xstep[STEP_W-1]}}, cfg_q.xstep};
        yinc    = {{EXT_W{cfg_q.ystep[STEP_W-1]}}, cfg_q.ystep};
        row_end = (xrem == CNT_W'(1));
        blk_end = row_end && (yrem == CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
            xrem <= '0;
            yrem <= '0;
        end else if (load) begin
            addr <= cfg_d.start;
            xrem <= cfg_d.xcnt;
            yrem <= cfg_d.ycnt;
        end else if (step) begin
            if (blk_end) begin
                addr <= cfg_q.start;
                xrem <= cfg_q.xcnt;
                yrem <= cfg_q.ycnt;
            end else if (row_end) begin
                addr <= addr + yinc;
                xrem <= cfg_q.xcnt;
                yrem <= yrem - CNT_W'(1);
            end else begin
                addr <= addr + xinc;
                xrem <= xrem - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
    import dma2d_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic zero_cnt,
    input  logic repeat_en,
    input  logic fire,
    input  logic blk_end,
    input  logic done_clr,
    output logic load,
    output logic addr_valid,
    output logic run,
    output logic err,
    output logic done
);
    dma2d_state_e state, state_nx;
    logic         finish;

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        finish   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (en) begin
                    if (zero_cnt) state_nx = ST_FAULT;
                    else begin
                        state_nx = ST_RUN;
                        load     = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (!en) state_nx = ST_IDLE;
                else if (fire && blk_end && !repeat_en) begin
                    state_nx = ST_HALT;
                    finish   = 1'b1;
                end
            end
            ST_HALT:  if (!en) state_nx = ST_IDLE;
            ST_FAULT: if (!en) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         done <= 1'b0;
        else if (finish)    done <= 1'b1;
        else if (done_clr)  done <= 1'b0;
    end

    always_comb begin
        addr_valid = (state == ST_RUN);
        run        = (state == ST_RUN);
        err        = (state == ST_FAULT);
    end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
    import dma2d_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [CNT_W-1:0]  cfg_xcnt,
    input  logic [STEP_W-1:0] cfg_xstep,
    input  logic [CNT_W-1:0]  cfg_ycnt,
    input  logic [STEP_W-1:0] cfg_ystep,
    input  logic              cfg_wide,
    input  logic              cfg_repeat,
    input  logic              addr_ready,
    input  logic              done_clr,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic              xfer_wide,
    output logic              run,
    output logic              done,
    output logic              err
);
    dma2d_cfg_t cfg_d, cfg_q;
    logic       load, fire, row_end, blk_end, zero_cnt;

    always_comb begin
        cfg_d.start     = cfg_start;
        cfg_d.xcnt      = cfg_xcnt;
        cfg_d.xstep     = cfg_xstep;
        cfg_d.ycnt      = cfg_ycnt;
        cfg_d.ystep     = cfg_ystep;
        cfg_d.wide      = cfg_wide;
        cfg_d.repeat_en = cfg_repeat;
        zero_cnt        = (cfg_xcnt == '0) || (cfg_ycnt == '0);
        fire            = addr_valid && addr_ready;
        xfer_wide       = cfg_q.wide;
    end

    dma2d_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .capture(load), .cfg_d(cfg_d), .cfg_q(cfg_q)
    );

    dma2d_walker u_walk (
        .clk(clk), .rst_n(rst_n), .load(load), .step(fire),
        .cfg_d(cfg_d), .cfg_q(cfg_q), .addr(addr),
        .row_end(row_end), .blk_end(blk_end)
    );

    dma2d_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .zero_cnt(zero_cnt),
        .repeat_en(cfg_q.repeat_en), .fire(fire), .blk_end(blk_end),
        .done_clr(done_clr), .load(load), .addr_valid(addr_valid),
        .run(run), .err(err), .done(done)
    );
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk
    import dma2d_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              addr_ready,
    input logic              done_clr,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] addr,
    input logic              run,
    input logic              done,
    input logic              err
);
    p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready && en) |=> (addr_valid && $stable(addr)));

    p_no_addr_in_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !addr_valid);

    p_done_from_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(run));

    p_clear_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !run) |=> !done);

    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !en) |=> (!run && !addr_valid));

    p_err_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !en) |=> !err);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .addr_ready(addr_ready),
    .done_clr(done_clr), .addr_valid(addr_valid), .addr(addr),
    .run(run), .done(done), .err(err)
);

// File: tb/dma2d_addr_gen_tb.sv
module dma2d_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] cfg_start = '0;
    logic [15:0] cfg_xcnt = '0, cfg_xstep = '0, cfg_ycnt = '0, cfg_ystep = '0;
    logic        cfg_wide = 1'b0, cfg_repeat = 1'b0;
    logic        addr_ready = 1'b1, done_clr = 1'b0;
    logic        addr_valid, xfer_wide, run, done, err;
    logic [31:0] addr;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dma2d_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_start(cfg_start),
        .cfg_xcnt(cfg_xcnt), .cfg_xstep(cfg_xstep), .cfg_ycnt(cfg_ycnt),
        .cfg_ystep(cfg_ystep), .cfg_wide(cfg_wide), .cfg_repeat(cfg_repeat),
        .addr_ready(addr_ready), .done_clr(done_clr), .addr_valid(addr_valid),
        .addr(addr), .xfer_wide(xfer_wide), .run(run), .done(done), .err(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [31:0] s, input int xc, input int xs,
                         input int yc, input int ys, input logic w, input logic r);
        cfg_start = s; cfg_xcnt = 16'(xc); cfg_xstep = 16'(xs);
        cfg_ycnt = 16'(yc); cfg_ystep = 16'(ys); cfg_wide = w; cfg_repeat = r;
    endtask

    // Walk one block with ready high; checks every address (R2/R3/R4)
    task automatic walk(input logic [31:0] s, input int xc, input int xs,
                        input int yc, input int ys);
        logic [31:0] a = s;
        for (int y = 0; y < yc; y++) begin
            for (int x = 0; x < xc; x++) begin
                @(negedge clk);
                chk("R2 valid", {31'b0, addr_valid}, 32'd1);
                chk((x == 0) ? "R4 row start addr" : "R3 in-row addr", addr, a);
                if (x == xc - 1) a = a + {{16{ys[15]}}, ys[15:0]};
                else             a = a + {{16{xs[15]}}, xs[15:0]};
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset flags", {28'b0, addr_valid, run, done, err}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_stop();
        setup(32'h1000, 4, 4, 3, 12, 1'b1, 1'b0);
        @(negedge clk); en = 1'b1;
        walk(32'h1000, 4, 4, 3, 12);
        chk("R12 wide", {31'b0, xfer_wide}, 32'd1);
        @(negedge clk);
        chk("R5 end flags", {29'b0, addr_valid, run, done}, 32'b001);
        repeat (3) @(negedge clk);
        chk("R6 done sticky", {31'b0, done}, 32'd1);
        done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        chk("R6 done cleared", {31'b0, done}, 32'd0);
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_wrap();
        setup(32'h4, 3, -4, 2, 16, 1'b0, 1'b0);
        @(negedge clk); en = 1'b1;
        walk(32'h4, 3, -4, 2, 16);
        chk("R12 narrow", {31'b0, xfer_wide}, 32'd0);
        @(negedge clk);
        chk("R5 done after wrap block", {31'b0, done}, 32'd1);
        en = 1'b0; done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    task automatic t_stall();
        setup(32'h200, 3, 8, 1, 0, 1'b1, 1'b0);
        addr_ready = 1'b0;
        @(negedge clk); en = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R10 stall valid", {31'b0, addr_valid}, 32'd1);
            chk("R10 stall addr", addr, 32'h200);
        end
        addr_ready = 1'b1;
        @(negedge clk);
        chk("R3 after stall", addr, 32'h208);
        @(negedge clk);
        chk("R3 after stall 2", addr, 32'h210);
        @(negedge clk);
        chk("R5 stop after 3", {30'b0, run, done}, 32'b01);
        en = 1'b0; done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    task automatic t_repeat();
        setup(32'h8000, 2, 2, 2, 6, 1'b1, 1'b1);
        @(negedge clk); en = 1'b1;
        repeat (3) walk(32'h8000, 2, 2, 2, 6);
        @(negedge clk);
        chk("R7 restart addr", addr, 32'h8000);
        chk("R7 no done", {30'b0, run, done}, 32'b10);
        en = 1'b0;
        @(negedge clk);
        chk("R11 abort", {30'b0, addr_valid, run}, 32'd0);
    endtask

    task automatic t_zero();
        setup(32'h40, 0, 4, 5, 4, 1'b1, 1'b0);
        @(negedge clk); en = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R8 err no addr", {30'b0, err, addr_valid}, 32'b10);
        end
        en = 1'b0;
        @(negedge clk);
        chk("R8 err released", {31'b0, err}, 32'd0);
        setup(32'h40, 5, 4, 0, 4, 1'b1, 1'b0);
        en = 1'b1;
        @(negedge clk);
        chk("R8 zero rows", {30'b0, err, addr_valid}, 32'b10);
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_live_cfg();
        setup(32'h3000, 4, 4, 1, 0, 1'b0, 1'b0);
        @(negedge clk); en = 1'b1;
        @(negedge clk);
        chk("R9 first", addr, 32'h3000);
        setup(32'h5000, 2, 1, 1, 0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R9 step unchanged", addr, 32'h3004);
        chk("R9 width unchanged", {31'b0, xfer_wide}, 32'd0);
        @(negedge clk); @(negedge clk);
        chk("R9 count unchanged", addr, 32'h300C);
        en = 1'b0;
        @(negedge clk); en = 1'b1;
        @(negedge clk);
        chk("R9 new start", addr, 32'h5000);
        chk("R12 new width", {31'b0, xfer_wide}, 32'd1);
        en = 1'b0; done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_stop();
                t_wrap();
                t_stall();
                t_repeat();
                t_zero();
                t_live_cfg();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule